// File: doc/BRIEF.md
# DMA Bus Tenure Throttle

This block decides when a DMA engine may hold a shared system bus and how long it has to stay away before asking again. A 3-bit on-time code sets the longest time the engine may keep the bus once the bus is granted. The top code value removes that limit, so the engine keeps the bus until the transfer finishes. A 3-bit off-time code sets the shortest gap the engine must leave between giving the bus up and asking for it again. Both windows are counted in ticks of an external 1 µs strobe.

The block drives a bus request toward the arbiter and receives the grant back. It gives the DMA datapath a permission-to-transfer level. When the tenure window runs out, permission is removed at once. The bus request is held until the datapath signals a transfer boundary, and it is released there. A transfer-done flag ends everything immediately. A dropped DMA request also returns the block to idle. No data passes through the block, so every pin is a plain control level and there is no valid/ready handshake or back-pressure to define.

Top module: `dma_tenure_throttle`

## Requirements
- R1: During and right after reset, `bus_req` and `xfer_permit` are low.
- R2: From idle, a high `dma_req` raises `bus_req` on the next cycle. `xfer_permit` stays low until `bus_grant` has been seen while requesting, and it rises the cycle after that grant.
- R3: For `on_code` values 0 to 6, the tenure window is 16 << `on_code` ticks (16 to 1024), counted from the grant. `xfer_permit` falls in the cycle after the tick that completes the window.
- R4: `on_code` = 7 (all ones) sets no tenure limit: `xfer_permit` stays high on the bus however many ticks arrive.
- R5: After the tenure window has expired, `bus_req` stays high until a cycle with `xfer_boundary` high, and it falls the cycle after. A boundary seen before expiry has no effect.
- R6: After the release, `bus_req` stays low while the off window counts down. The off window is 0 ticks for `off_code` = 0 and 8 << `off_code` ticks otherwise (16 to 1024). If `dma_req` is still high, `bus_req` rises the cycle after the tick that completes the window.
- R7: With `off_code` = 0, `bus_req` is low for exactly one cycle between release and the next request.
- R8: A high `xfer_done` in any state sends the block to idle on the next cycle, with both outputs low, and clears both window counters, so no leftover off gap delays the next request.
- R9: If `dma_req` is low while requesting or on the bus, the block goes to idle on the next cycle and both outputs fall.
- R10: The window counters change only in cycles where `tick_1us` is high. Without ticks, a tenure never expires.
- R11: Each code is sampled when its window is loaded: the on code at the grant, and the off code at the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| on_code | input | 3 | Tenure limit code (7 = until done) |
| off_code | input | 3 | Minimum off-bus gap code |
| tick_1us | input | 1 | One-cycle 1 µs strobe |
| dma_req | input | 1 | DMA engine wants the bus |
| xfer_done | input | 1 | Transfer finished / no more data |
| xfer_boundary | input | 1 | Datapath is at a transfer boundary |
| bus_grant | input | 1 | Grant from the bus arbiter |
| bus_req | output | 1 | Bus request to the arbiter |
| xfer_permit | output | 1 | Datapath may move data |

## Verification
The bench places ticks at the edges of each window. For the 16-tick and 64-tick tenures it checks one tick before expiry and exactly at expiry. An off-by-one counter shows up here as permission that lasts one tick too long or ends one tick too early. The bench holds a boundary high before expiry, which catches a design that releases the bus early. It also holds a boundary back after expiry, which catches a design that drops the request without waiting for it. The off gap is checked at its final tick and again with code 0; a design that skips the back-off, or stretches the code-0 gap past one cycle, gets the request timing wrong. A done flag raised midway through a back-off must clear the gap, and a long run with no ticks must not expire the tenure.

// File: rtl/dma_throttle_pkg.sv
package dma_throttle_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_REQUEST = 2'd1,
    ST_ON_BUS  = 2'd2,
    ST_BACKOFF = 2'd3
  } thr_state_e;
endpackage

// File: rtl/throttle_down_counter.sv
module throttle_down_counter #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  input  logic         en,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (clr)                       cnt_q <= '0;
    else if (load)                      cnt_q <= load_val;
    else if (en && tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/throttle_fsm.sv
module throttle_fsm
  import dma_throttle_pkg::*;
#(
  parameter int CODE_W   = 3,
  parameter int CNT_W    = 11,
  parameter int BASE_ON  = 16,
  parameter int BASE_OFF = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] on_code,
  input  logic [CODE_W-1:0] off_code,
  input  logic              dma_req,
  input  logic              xfer_done,
  input  logic              xfer_boundary,
  input  logic              bus_grant,
  input  logic              on_zero,
  input  logic              off_zero,
  output logic              cnt_clr,
  output logic              on_load,
  output logic              on_en,
  output logic [CNT_W-1:0]  on_val,
  output logic              off_load,
  output logic              off_en,
  output logic [CNT_W-1:0]  off_val,
  output logic              bus_req,
  output logic              xfer_permit
);
  localparam logic [CODE_W-1:0] UNLIMITED = '1;
  localparam logic [CNT_W-1:0]  ON_UNIT   = CNT_W'(BASE_ON);
  localparam logic [CNT_W-1:0]  OFF_UNIT  = CNT_W'(BASE_OFF);

  thr_state_e state_q, state_d;
  logic       unl_q;
  logic       on_expired;

  assign on_val     = ON_UNIT << on_code;
  assign off_val    = (off_code == '0) ? '0 : (OFF_UNIT << off_code);
  assign on_expired = !unl_q && on_zero;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (dma_req) state_d = ST_REQUEST;
      ST_REQUEST: begin
        if (!dma_req)       state_d = ST_IDLE;
        else if (bus_grant) state_d = ST_ON_BUS;
      end
      ST_ON_BUS: begin
        if (!dma_req)                        state_d = ST_IDLE;
        else if (on_expired && xfer_boundary) state_d = ST_BACKOFF;
      end
      ST_BACKOFF: if (off_zero) state_d = dma_req ? ST_REQUEST : ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
    if (xfer_done) state_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      unl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (xfer_done)    unl_q <= 1'b0;
      else if (on_load) unl_q <= (on_code == UNLIMITED);
    end
  end

  assign cnt_clr     = xfer_done;
  assign on_load     = (state_q == ST_REQUEST) && (state_d == ST_ON_BUS);
  assign off_load    = (state_q == ST_ON_BUS) && (state_d == ST_BACKOFF);
  assign on_en       = (state_q == ST_ON_BUS) && !unl_q;
  assign off_en      = (state_q == ST_BACKOFF);
  assign bus_req     = (state_q == ST_REQUEST) || (state_q == ST_ON_BUS);
  assign xfer_permit = (state_q == ST_ON_BUS) && !on_expired;
endmodule

// File: rtl/dma_tenure_throttle.sv
module dma_tenure_throttle #(
  parameter int CODE_W   = 3,
  parameter int BASE_ON  = 16,
  parameter int BASE_OFF = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] on_code,
  input  logic [CODE_W-1:0] off_code,
  input  logic              tick_1us,
  input  logic              dma_req,
  input  logic              xfer_done,
  input  logic              xfer_boundary,
  input  logic              bus_grant,
  output logic              bus_req,
  output logic              xfer_permit
);
  localparam int MAX_CODE = (1 << CODE_W) - 1;
  localparam int MAX_ON   = BASE_ON << (MAX_CODE - 1);
  localparam int MAX_OFF  = BASE_OFF << MAX_CODE;
  localparam int MAX_WIN  = (MAX_ON > MAX_OFF) ? MAX_ON : MAX_OFF;
  localparam int CNT_W    = $clog2(MAX_WIN + 1);

  logic             cnt_clr, on_load, on_en, off_load, off_en;
  logic             on_zero, off_zero;
  logic [CNT_W-1:0] on_val, off_val;

  throttle_fsm #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .BASE_ON(BASE_ON), .BASE_OFF(BASE_OFF)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .on_code(on_code), .off_code(off_code),
    .dma_req(dma_req), .xfer_done(xfer_done), .xfer_boundary(xfer_boundary),
    .bus_grant(bus_grant), .on_zero(on_zero), .off_zero(off_zero),
    .cnt_clr(cnt_clr), .on_load(on_load), .on_en(on_en), .on_val(on_val),
    .off_load(off_load), .off_en(off_en), .off_val(off_val),
    .bus_req(bus_req), .xfer_permit(xfer_permit)
  );

  throttle_down_counter #(.W(CNT_W)) on_cnt_i (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .load(on_load),
    .load_val(on_val), .tick(tick_1us), .en(on_en), .zero(on_zero)
  );

  throttle_down_counter #(.W(CNT_W)) off_cnt_i (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .load(off_load),
    .load_val(off_val), .tick(tick_1us), .en(off_en), .zero(off_zero)
  );
endmodule

// File: rtl/dma_tenure_throttle_chk.sv
module dma_tenure_throttle_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_1us,
  input logic dma_req,
  input logic xfer_done,
  input logic xfer_boundary,
  input logic bus_grant,
  input logic bus_req,
  input logic xfer_permit
);
  assert_permit_only_with_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_permit |-> bus_req);

  assert_permit_after_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_permit) |-> $past(bus_grant));

  assert_permit_drop_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_permit) |-> $past(tick_1us || xfer_done || !dma_req));

  assert_release_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(xfer_boundary || xfer_done || !dma_req));

  assert_done_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> (!bus_req && !xfer_permit));

  assert_req_drop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_req |=> !bus_req);
endmodule

bind dma_tenure_throttle dma_tenure_throttle_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .dma_req(dma_req),
  .xfer_done(xfer_done), .xfer_boundary(xfer_boundary), .bus_grant(bus_grant),
  .bus_req(bus_req), .xfer_permit(xfer_permit)
);

// File: tb/dma_tenure_throttle_tb.sv
module dma_tenure_throttle_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] on_code, off_code;
  logic       tick_1us, dma_req, xfer_done, xfer_boundary, bus_grant;
  logic       bus_req, xfer_permit;
  int         n_checks = 0;
  int         n_fail = 0;
  int         cycles = 0;

  always #2 clk = ~clk;

  dma_tenure_throttle dut_i (
    .clk(clk), .rst_n(rst_n), .on_code(on_code), .off_code(off_code),
    .tick_1us(tick_1us), .dma_req(dma_req), .xfer_done(xfer_done),
    .xfer_boundary(xfer_boundary), .bus_grant(bus_grant),
    .bus_req(bus_req), .xfer_permit(xfer_permit)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_checks = n_checks + 1;
      n_fail   = n_fail + 1;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_1us = 1'b1;
      step();
      tick_1us = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; on_code = 3'd0; off_code = 3'd0; tick_1us = 1'b0;
    dma_req = 1'b0; xfer_done = 1'b0; xfer_boundary = 1'b0; bus_grant = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic to_bus();
    dma_req = 1'b1;
    step();
    bus_grant = 1'b1;
    step();
  endtask

  task automatic release_bus();
    xfer_boundary = 1'b1;
    step();
    xfer_boundary = 1'b0;
    bus_grant = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step();
    chk("R1 bus_req in reset", bus_req, 1'b0);
    chk("R1 permit in reset", xfer_permit, 1'b0);
    do_reset();
    chk("R1 bus_req after reset", bus_req, 1'b0);
    chk("R1 permit after reset", xfer_permit, 1'b0);
  endtask

  task automatic t_tenure_code0();
    do_reset();
    on_code = 3'd0; off_code = 3'd1;
    dma_req = 1'b1;
    step();
    chk("R2 request raised", bus_req, 1'b1);
    chk("R2 no permit before grant", xfer_permit, 1'b0);
    step();
    chk("R2 still no permit", xfer_permit, 1'b0);
    bus_grant = 1'b1;
    step();
    chk("R2 permit after grant", xfer_permit, 1'b1);
    ticks(15);
    chk("R3 permit at tick 15 of 16", xfer_permit, 1'b1);
    ticks(1);
    chk("R3 permit gone at tick 16", xfer_permit, 1'b0);
    chk("R5 request held until boundary", bus_req, 1'b1);
    step(); step();
    chk("R5 request still held", bus_req, 1'b1);
    release_bus();
    chk("R5 released at boundary", bus_req, 1'b0);
    ticks(15);
    chk("R6 off gap tick 15 of 16", bus_req, 1'b0);
    ticks(1);
    chk("R6 off gap tick 16", bus_req, 1'b0);
    step();
    chk("R6 re-request after gap", bus_req, 1'b1);
  endtask

  task automatic t_tenure_code2();
    do_reset();
    on_code = 3'd2;
    to_bus();
    on_code = 3'd0;
    ticks(63);
    chk("R3 R11 code 2 tick 63 of 64", xfer_permit, 1'b1);
    ticks(1);
    chk("R3 code 2 tick 64", xfer_permit, 1'b0);
  endtask

  task automatic t_early_boundary();
    do_reset();
    on_code = 3'd0;
    to_bus();
    xfer_boundary = 1'b1;
    step(); step(); step();
    xfer_boundary = 1'b0;
    chk("R5 early boundary keeps req", bus_req, 1'b1);
    chk("R5 early boundary keeps permit", xfer_permit, 1'b1);
  endtask

  task automatic t_unlimited();
    do_reset();
    on_code = 3'd7;
    to_bus();
    ticks(1100);
    chk("R4 unlimited still permitted", xfer_permit, 1'b1);
    xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
    chk("R8 done drops req", bus_req, 1'b0);
    chk("R8 done drops permit", xfer_permit, 1'b0);
  endtask

  task automatic t_off_zero();
    do_reset();
    on_code = 3'd0; off_code = 3'd0;
    to_bus();
    ticks(16);
    release_bus();
    chk("R7 one-cycle low", bus_req, 1'b0);
    step();
    chk("R7 re-request next cycle", bus_req, 1'b1);
  endtask

  task automatic t_done_in_backoff();
    do_reset();
    on_code = 3'd0; off_code = 3'd3;
    to_bus();
    ticks(16);
    release_bus();
    ticks(10);
    chk("R6 mid-gap low", bus_req, 1'b0);
    xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
    chk("R8 done in backoff idle", bus_req, 1'b0);
    step();
    chk("R8 gap cleared, request again", bus_req, 1'b1);
  endtask

  task automatic t_req_drop();
    do_reset();
    dma_req = 1'b1;
    step();
    dma_req = 1'b0;
    step();
    chk("R9 drop while requesting", bus_req, 1'b0);
    to_bus();
    dma_req = 1'b0;
    step();
    chk("R9 drop on bus req", bus_req, 1'b0);
    chk("R9 drop on bus permit", xfer_permit, 1'b0);
  endtask

  task automatic t_no_tick();
    do_reset();
    on_code = 3'd0;
    to_bus();
    for (int i = 0; i < 200; i++) step();
    chk("R10 no tick no expiry", xfer_permit, 1'b1);
  endtask

  initial begin
    t_reset();
    t_tenure_code0();
    t_tenure_code2();
    t_early_boundary();
    t_unlimited();
    t_off_zero();
    t_done_in_backoff();
    t_req_drop();
    t_no_tick();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule